// File: doc/BRIEF.md
# Direct-Matching Operand Token Store

This block pairs up operand tokens for a token-driven dataflow engine. Each token that arrives names a frame (a base address in a small frame memory), an instruction pointer, a data value and the side (left or right) of the instruction input it feeds. The block fetches the instruction word at that pointer. It then finds the instruction's matching slot by adding the slot offset in the word to the frame base, and reads the presence bit of that slot. The first operand of a two-input instruction is parked in the slot. The second one finds the bit set, takes the parked value back and clears the bit. The instruction then fires with both operands placed on their proper sides.

A firing instruction emits one or two result tokens. Each result keeps the frame of the firing token. It points to the current instruction pointer plus a displacement given per destination, and carries that destination's side flag. Results queue in a small output FIFO. The input stalls whenever the FIFO could not take a full pair of results. An instruction flagged as single-input fires on its only token and leaves the presence bits alone. Both the instruction memory and the frame memory have write ports, so a test or an outer loader can fill them before tokens flow.

Top module: `dm_token_match`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0, `tok_ready` is 1 and every presence bit is clear.
- R2: The matching slot is (token frame + instruction slot offset) modulo 64. A token for a two-input instruction that finds the slot's presence bit clear stores its value there, sets the bit and produces no result token.
- R3: A token for a two-input instruction that finds the presence bit set fires the instruction with the stored value and its own value, and clears the bit. The next token for that slot is parked again.
- R4: The incoming token's side flag (0 left, 1 right) places its value, and the stored value takes the other side. The 17-bit instruction word is, from bit 16 down: single-input flag (16), opcode (15:14), slot offset (13:11), first displacement (10:7), first side (6), second-destination enable (5), second displacement (4:1), second side (0). Opcodes are 0 left+right, 1 left-right, 2 left AND right, 3 left XOR right, all modulo 2^16.
- R5: Every firing emits a first result token. When the enable bit is set it also emits a second one right after the first. Each result has the firing frame, the pointer (current pointer + displacement) modulo 64 and the side from the word.
- R6: A single-input instruction fires on one token. Its value goes to the token's side and the other side is 0. The slot's presence bit and a value parked there stay unchanged.
- R7: A preload write to the frame memory sets a slot's value and presence bit. A later token for that slot fires against the preloaded value if the bit was written as 1, and parks if it was written as 0.
- R8: Result tokens leave in the order they were produced. While `res_valid` is 1 and `res_ready` is 0, the result token holds steady.
- R9: `tok_ready` drops only while an accepted token is waiting for the output FIFO to have room for two results. No accepted token is lost and the FIFO never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Input token present |
| tok_ready | output | 1 | Block accepts the input token |
| tok_fp | input | 6 | Token frame base address |
| tok_ip | input | 6 | Token instruction pointer |
| tok_data | input | 16 | Token value |
| tok_side | input | 1 | Token side, 0 left, 1 right |
| res_valid | output | 1 | Result token present |
| res_ready | input | 1 | Consumer takes the result token |
| res_fp | output | 6 | Result frame base address |
| res_ip | output | 6 | Result instruction pointer |
| res_data | output | 16 | Result value |
| res_side | output | 1 | Result side |
| iw_we | input | 1 | Instruction memory write enable |
| iw_addr | input | 6 | Instruction memory write address |
| iw_data | input | 17 | Instruction word to write |
| fw_we | input | 1 | Frame memory preload enable |
| fw_addr | input | 6 | Frame slot to preload |
| fw_data | input | 16 | Value to preload |
| fw_full | input | 1 | Presence bit to preload |

## Verification
The bench sweeps every opcode with both arrival orders and a spread of value pairs. A design that ignores the side flags would give reversed subtraction results when the right operand arrives first. Frames and displacements are chosen so that both the slot address and the result pointer wrap past 63. A design that carries into a seventh bit would hit the wrong slot or emit the wrong pointer. A third token to a slot that just fired must park again, which exposes a presence bit that is never cleared. A single-input firing placed on a slot that holds a parked value must leave that value for its later partner, which catches a design that clears the bit. Holding the consumer off fills the FIFO and checks that input stalls, no result is reordered or lost, and the head token stays steady.

// File: rtl/dmts_pkg.sv
package dmts_pkg;

  localparam int unsigned OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } dmts_op_e;

endpackage

// File: rtl/dmts_alu.sv
module dmts_alu
  import dmts_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  dmts_op_e        op,
  input  logic [DW-1:0]   lhs,
  input  logic [DW-1:0]   rhs,
  output logic [DW-1:0]   y
);

  always_comb begin
    case (op)
      OP_ADD:  y = lhs + rhs;
      OP_SUB:  y = lhs - rhs;
      OP_AND:  y = lhs & rhs;
      OP_XOR:  y = lhs ^ rhs;
      default: y = lhs + rhs;
    endcase
  end

endmodule

// File: rtl/dmts_frame_store.sv
// Frame memory: one value and one presence bit per slot. Presence bits reset,
// values do not. A preload write wins over a match update in the same cycle.
module dmts_frame_store #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_full,
  output logic [DW-1:0]     rd_data,
  input  logic              upd_en,
  input  logic              upd_set,
  input  logic [DW-1:0]     upd_data,
  input  logic              pre_we,
  input  logic [AW-1:0]     pre_addr,
  input  logic [DW-1:0]     pre_data,
  input  logic              pre_full,
  output logic [(1<<AW)-1:0] pres_vec
);

  localparam int unsigned N = 1 << AW;

  logic [N-1:0]  full_q;
  logic [N-1:0]  full_d;
  logic [DW-1:0] val_q [N];

  always_comb begin
    full_d = full_q;
    if (upd_en) full_d[rd_addr] = upd_set;
    if (pre_we) full_d[pre_addr] = pre_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (pre_we)                 val_q[pre_addr] <= pre_data;
    else if (upd_en && upd_set) val_q[rd_addr]  <= upd_data;
  end

  assign rd_full  = full_q[rd_addr];
  assign rd_data  = val_q[rd_addr];
  assign pres_vec = full_q;

endmodule

// File: rtl/dmts_result_fifo.sv
// Result queue taking up to two entries per cycle and giving one.
// DEPTH must be a power of two, at least 2.
module dmts_result_fifo #(
  parameter int unsigned W     = 29,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push0,
  input  logic [W-1:0]  din0,
  input  logic          push1,
  input  logic [W-1:0]  din1,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          not_empty,
  output logic [CW-1:0] space
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d, wp_plus1;
  logic [CW-1:0] cnt_q, cnt_d;

  assign wp_plus1 = wp_q + AW'(1);

  always_comb begin
    wp_d  = wp_q + AW'(push0) + AW'(push1);
    rp_d  = rp_q + AW'(pop);
    cnt_d = cnt_q + CW'(push0) + CW'(push1) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push0) mem_q[wp_q]     <= din0;
    if (push1) mem_q[wp_plus1] <= din1;
  end

  assign dout      = mem_q[rp_q];
  assign not_empty = (cnt_q != '0);
  assign space     = CW'(DEPTH) - cnt_q;

endmodule

// File: rtl/dm_token_match.sv
module dm_token_match
  import dmts_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned FAW        = 6,
  parameter int unsigned IPW        = 6,
  parameter int unsigned OFFW       = 3,
  parameter int unsigned DISPW      = 4,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tok_valid,
  output logic                          tok_ready,
  input  logic [FAW-1:0]                tok_fp,
  input  logic [IPW-1:0]                tok_ip,
  input  logic [DW-1:0]                 tok_data,
  input  logic                          tok_side,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [FAW-1:0]                res_fp,
  output logic [IPW-1:0]                res_ip,
  output logic [DW-1:0]                 res_data,
  output logic                          res_side,
  input  logic                          iw_we,
  input  logic [IPW-1:0]                iw_addr,
  input  logic [2*DISPW+OFFW+OP_W+3:0]  iw_data,
  input  logic                          fw_we,
  input  logic [FAW-1:0]                fw_addr,
  input  logic [DW-1:0]                 fw_data,
  input  logic                          fw_full
);

  // Instruction word layout, LSB first.
  localparam int unsigned IW         = 2*DISPW + OFFW + OP_W + 4;
  localparam int unsigned D1_SIDE    = 0;
  localparam int unsigned D1_DISP_LO = 1;
  localparam int unsigned D1_EN      = DISPW + 1;
  localparam int unsigned D0_SIDE    = DISPW + 2;
  localparam int unsigned D0_DISP_LO = DISPW + 3;
  localparam int unsigned OFF_LO     = 2*DISPW + 3;
  localparam int unsigned OP_LO      = OFF_LO + OFFW;
  localparam int unsigned MONO_BIT   = OP_LO + OP_W;
  localparam int unsigned IMEM_N     = 1 << IPW;
  localparam int unsigned RES_W      = FAW + IPW + DW + 1;
  localparam int unsigned SPW        = $clog2(FIFO_DEPTH) + 1;

  // ---------------- declarations ----------------
  logic [IW-1:0]    imem_q [IMEM_N];
  logic             s1_valid_q, s1_valid_d;
  logic [FAW-1:0]   s1_fp_q;
  logic [IPW-1:0]   s1_ip_q;
  logic [DW-1:0]    s1_data_q;
  logic             s1_side_q;

  logic [IW-1:0]    instr;
  logic             mono;
  dmts_op_e         op;
  logic [OFFW-1:0]  off;
  logic [DISPW-1:0] d0_disp, d1_disp;
  logic             d0_side, d1_side, d1_en;

  logic [FAW-1:0]   slot;
  logic             hit;
  logic [DW-1:0]    rd_data;
  logic [(1<<FAW)-1:0] pres_vec;
  logic             fire, room, adv, accept;
  logic [DW-1:0]    stored, lhs, rhs, y;
  logic             push0, push1;
  logic [RES_W-1:0] din0, din1, dout;
  logic [SPW-1:0]   fifo_space;
  logic             upd_en;

  // ---------------- instruction memory ----------------
  always_ff @(posedge clk) begin
    if (iw_we) imem_q[iw_addr] <= iw_data;
  end

  // ---------------- input stage ----------------
  assign room      = (fifo_space >= SPW'(2));
  assign adv       = s1_valid_q & room;
  assign tok_ready = ~s1_valid_q | room;
  assign accept    = tok_valid & tok_ready;

  always_comb begin
    s1_valid_d = s1_valid_q;
    if (adv)    s1_valid_d = 1'b0;
    if (accept) s1_valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid_q <= 1'b0;
    else        s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_fp_q   <= tok_fp;
      s1_ip_q   <= tok_ip;
      s1_data_q <= tok_data;
      s1_side_q <= tok_side;
    end
  end

  // ---------------- decode ----------------
  assign instr   = imem_q[s1_ip_q];
  assign mono    = instr[MONO_BIT];
  assign op      = dmts_op_e'(instr[OP_LO +: OP_W]);
  assign off     = instr[OFF_LO +: OFFW];
  assign d0_disp = instr[D0_DISP_LO +: DISPW];
  assign d0_side = instr[D0_SIDE];
  assign d1_en   = instr[D1_EN];
  assign d1_disp = instr[D1_DISP_LO +: DISPW];
  assign d1_side = instr[D1_SIDE];

  // ---------------- matching ----------------
  assign slot   = s1_fp_q + FAW'(off);
  assign fire   = mono | hit;
  assign upd_en = adv & ~mono;

  dmts_frame_store #(
    .DW (DW),
    .AW (FAW)
  ) i_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (slot),
    .rd_full  (hit),
    .rd_data  (rd_data),
    .upd_en   (upd_en),
    .upd_set  (~hit),
    .upd_data (s1_data_q),
    .pre_we   (fw_we),
    .pre_addr (fw_addr),
    .pre_data (fw_data),
    .pre_full (fw_full),
    .pres_vec (pres_vec)
  );

  // Stored operand sits opposite the incoming one; single-input uses zero.
  assign stored = mono ? '0 : rd_data;
  assign lhs    = s1_side_q ? stored    : s1_data_q;
  assign rhs    = s1_side_q ? s1_data_q : stored;

  dmts_alu #(
    .DW (DW)
  ) i_alu (
    .op  (op),
    .lhs (lhs),
    .rhs (rhs),
    .y   (y)
  );

  // ---------------- result tokens ----------------
  assign push0 = adv & fire;
  assign push1 = adv & fire & d1_en;
  assign din0  = {s1_fp_q, s1_ip_q + IPW'(d0_disp), y, d0_side};
  assign din1  = {s1_fp_q, s1_ip_q + IPW'(d1_disp), y, d1_side};

  dmts_result_fifo #(
    .W     (RES_W),
    .DEPTH (FIFO_DEPTH)
  ) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push0     (push0),
    .din0      (din0),
    .push1     (push1),
    .din1      (din1),
    .pop       (res_valid & res_ready),
    .dout      (dout),
    .not_empty (res_valid),
    .space     (fifo_space)
  );

  assign res_side = dout[0];
  assign res_data = dout[1 +: DW];
  assign res_ip   = dout[DW+1 +: IPW];
  assign res_fp   = dout[DW+IPW+1 +: FAW];

endmodule

// File: rtl/dmts_checker.sv
module dmts_checker #(
  parameter int unsigned DW  = 16,
  parameter int unsigned FAW = 6,
  parameter int unsigned IPW = 6,
  parameter int unsigned SPW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tok_ready,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [FAW-1:0]       res_fp,
  input logic [IPW-1:0]       res_ip,
  input logic [DW-1:0]        res_data,
  input logic                 res_side,
  input logic                 s1_valid,
  input logic                 adv,
  input logic                 mono,
  input logic                 hit,
  input logic                 d1_en,
  input logic                 push0,
  input logic                 push1,
  input logic [FAW-1:0]       slot,
  input logic [(1<<FAW)-1:0]  pres_vec,
  input logic                 fw_we,
  input logic [SPW-1:0]       fifo_space
);

  a_r2_park_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !mono && !hit) |-> !push0);

  a_r3_bit_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !mono && !fw_we) |=> (pres_vec[$past(slot)] == !$past(hit)));

  a_r5_dest_count: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (mono || hit)) |-> (push0 && (push1 == d1_en)));

  a_r6_mono_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mono && !fw_we) |=> (pres_vec == $past(pres_vec)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) &&
      $stable(res_ip) && $stable(res_fp) && $stable(res_side)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push0 |-> (fifo_space >= (push1 ? SPW'(2) : SPW'(1))));

  a_r9_stall_reason: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_ready |-> (s1_valid && res_valid));

endmodule

bind dm_token_match dmts_checker #(
  .DW  (DW),
  .FAW (FAW),
  .IPW (IPW),
  .SPW (SPW)
) i_dmts_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tok_ready  (tok_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_fp     (res_fp),
  .res_ip     (res_ip),
  .res_data   (res_data),
  .res_side   (res_side),
  .s1_valid   (s1_valid_q),
  .adv        (adv),
  .mono       (mono),
  .hit        (hit),
  .d1_en      (d1_en),
  .push0      (push0),
  .push1      (push1),
  .slot       (slot),
  .pres_vec   (pres_vec),
  .fw_we      (fw_we),
  .fifo_space (fifo_space)
);

// File: tb/test_dm_token_match.sv
module test_dm_token_match;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tok_valid, tok_side, res_ready;
  logic [5:0]  tok_fp, tok_ip;
  logic [15:0] tok_data;
  logic        tok_ready, res_valid, res_side;
  logic [5:0]  res_fp, res_ip;
  logic [15:0] res_data;
  logic        iw_we, fw_we, fw_full;
  logic [5:0]  iw_addr, fw_addr;
  logic [16:0] iw_data;
  logic [15:0] fw_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [28:0] exp_q [$];

  // Bench copy of each instruction's fields, filled by load_instr.
  logic       t_mono [64];
  logic [1:0] t_op   [64];
  logic [2:0] t_off  [64];
  logic [3:0] t_d0   [64];
  logic       t_d0s  [64];
  logic       t_d1e  [64];
  logic [3:0] t_d1   [64];
  logic       t_d1s  [64];

  always #4 clk = ~clk;

  dm_token_match i_dm_token_match (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_fp(tok_fp),
    .tok_ip(tok_ip), .tok_data(tok_data), .tok_side(tok_side),
    .res_valid(res_valid), .res_ready(res_ready), .res_fp(res_fp),
    .res_ip(res_ip), .res_data(res_data), .res_side(res_side),
    .iw_we(iw_we), .iw_addr(iw_addr), .iw_data(iw_data),
    .fw_we(fw_we), .fw_addr(fw_addr), .fw_data(fw_data), .fw_full(fw_full)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] calc(input logic [1:0] op, input logic [15:0] l, input logic [15:0] r);
    case (op)
      2'd0:    return l + r;
      2'd1:    return l - r;
      2'd2:    return l & r;
      default: return l ^ r;
    endcase
  endfunction

  task automatic load_instr(input logic [5:0] ip, input logic mono, input logic [1:0] op,
                            input logic [2:0] off, input logic [3:0] d0, input logic d0s,
                            input logic d1e, input logic [3:0] d1, input logic d1s);
    t_mono[ip] = mono; t_op[ip] = op; t_off[ip] = off; t_d0[ip] = d0;
    t_d0s[ip] = d0s; t_d1e[ip] = d1e; t_d1[ip] = d1; t_d1s[ip] = d1s;
    @(negedge clk);
    iw_we = 1'b1; iw_addr = ip;
    iw_data = {mono, op, off, d0, d0s, d1e, d1, d1s};   // R4 layout
    @(negedge clk);
    iw_we = 1'b0;
  endtask

  // R5: expected result tokens for a firing of instruction ip in frame fp.
  task automatic expect_fire(input logic [5:0] fp, input logic [5:0] ip,
                             input logic [15:0] l, input logic [15:0] r);
    logic [15:0] y;
    y = calc(t_op[ip], l, r);
    exp_q.push_back({fp, 6'(ip + 6'(t_d0[ip])), y, t_d0s[ip]});
    if (t_d1e[ip]) exp_q.push_back({fp, 6'(ip + 6'(t_d1[ip])), y, t_d1s[ip]});
  endtask

  task automatic send(input logic [5:0] fp, input logic [5:0] ip,
                      input logic [15:0] d, input logic side);
    @(negedge clk);
    tok_valid = 1'b1; tok_fp = fp; tok_ip = ip; tok_data = d; tok_side = side;
    #1;
    while (!tok_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 tok_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 60) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic quiet(input string req);
    repeat (4) @(negedge clk);
    #2;
    check(res_valid == 1'b0, req, res_valid, 0);
  endtask

  // Result monitor (R8 ordering, R5 fields).
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", {res_fp, res_ip, res_data, res_side}, 0);
        end else begin
          logic [28:0] e;
          e = exp_q.pop_front();
          check({res_fp, res_ip, res_data, res_side} == e, "R5/R8 result token",
                {res_fp, res_ip, res_data, res_side}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [15:0] va(input int i);
    case (i)
      0: return 16'd3;    1: return 16'hFFFF; 2: return 16'h8000;
      3: return 16'h1234; 4: return 16'h0000; default: return 16'h0007;
    endcase
  endfunction

  function automatic logic [15:0] vb(input int i);
    case (i)
      0: return 16'd5;    1: return 16'h0001; 2: return 16'h8000;
      3: return 16'h00FF; 4: return 16'h0000; default: return 16'hFFF0;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_fp = '0; tok_ip = '0; tok_data = '0;
    tok_side = 1'b0; res_ready = 1'b1; iw_we = 1'b0; iw_addr = '0; iw_data = '0;
    fw_we = 1'b0; fw_addr = '0; fw_data = '0; fw_full = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(res_valid == 1'b0 && tok_ready == 1'b1, "R1 in reset", {res_valid, tok_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
    check(tok_ready == 1'b1, "R1 tok_ready after reset", tok_ready, 1);

    load_instr(6'd0,  1'b0, 2'd0, 3'd1, 4'd3,  1'b0, 1'b1, 4'd7, 1'b1);
    load_instr(6'd1,  1'b0, 2'd1, 3'd2, 4'd1,  1'b1, 1'b0, 4'd0, 1'b0);
    load_instr(6'd2,  1'b0, 2'd2, 3'd3, 4'd15, 1'b0, 1'b1, 4'd2, 1'b0);
    load_instr(6'd3,  1'b0, 2'd3, 3'd4, 4'd5,  1'b1, 1'b1, 4'd9, 1'b1);
    load_instr(6'd60, 1'b0, 2'd1, 3'd6, 4'd15, 1'b0, 1'b1, 4'd4, 1'b1);
    load_instr(6'd62, 1'b1, 2'd1, 3'd6, 4'd2,  1'b0, 1'b0, 4'd0, 1'b0);
    load_instr(6'd63, 1'b1, 2'd0, 3'd0, 4'd1,  1'b1, 1'b1, 4'd3, 1'b0);

    // Sweep (R2, R3, R4, R5): opcodes, value pairs, both arrival orders,
    // frames spread so fp+off and ip+disp wrap.
    begin
      int n = 0;
      for (int k = 0; k < 5; k++) begin
        for (int v = 0; v < 6; v++) begin
          for (int ord = 0; ord < 2; ord++) begin
            logic [5:0] ip, fp;
            ip = (k == 4) ? 6'd60 : 6'(k);
            fp = 6'((n * 7 + 58) % 64);
            n++;
            if (ord == 0) send(fp, ip, va(v), 1'b0);
            else          send(fp, ip, vb(v), 1'b1);
            quiet("R2 first arrival parks");
            expect_fire(fp, ip, va(v), vb(v));   // R4 left=va, right=vb
            if (ord == 0) send(fp, ip, vb(v), 1'b1);
            else          send(fp, ip, va(v), 1'b0);
            drain("R3/R4 fire with ordered operands");
          end
        end
      end
    end

    // R3: a third token after a firing parks again.
    expect_fire(6'd20, 6'd3, 16'd5, 16'd9);
    send(6'd20, 6'd3, 16'd5, 1'b0);
    send(6'd20, 6'd3, 16'd9, 1'b1);
    drain("R3 pair fires");
    send(6'd20, 6'd3, 16'h00AA, 1'b1);
    quiet("R3 third token parks again");
    expect_fire(6'd20, 6'd3, 16'h000F, 16'h00AA);
    send(6'd20, 6'd3, 16'h000F, 1'b0);
    drain("R3 fourth token fires");

    // R6: single-input firing on a slot that holds a parked value (slot 12).
    send(6'd10, 6'd1, 16'd100, 1'b0);
    quiet("R6 park before single-input");
    expect_fire(6'd6, 6'd62, 16'd0, 16'd7);   // 0 - 7
    send(6'd6, 6'd62, 16'd7, 1'b1);
    drain("R6 single-input fires alone");
    expect_fire(6'd10, 6'd1, 16'd100, 16'd30);
    send(6'd10, 6'd1, 16'd30, 1'b1);
    drain("R6 parked value survives");
    expect_fire(6'd3, 6'd63, 16'd55, 16'd0);
    send(6'd3, 6'd63, 16'd55, 1'b0);
    drain("R6 single-input two destinations");

    // R7: preload full slot at (62+6)%64 = 4, then preload empty at slot 63.
    @(negedge clk);
    fw_we = 1'b1; fw_addr = 6'd4; fw_data = 16'd1000; fw_full = 1'b1;
    @(negedge clk);
    fw_we = 1'b0;
    expect_fire(6'd62, 6'd60, 16'd1000, 16'd1);
    send(6'd62, 6'd60, 16'd1, 1'b1);
    drain("R7 fire against preloaded slot");
    @(negedge clk);
    fw_we = 1'b1; fw_addr = 6'd63; fw_data = 16'd77; fw_full = 1'b0;
    @(negedge clk);
    fw_we = 1'b0;
    send(6'd62, 6'd0, 16'd8, 1'b0);      // slot 62+1 = 63
    quiet("R7 preloaded empty slot parks");
    expect_fire(6'd62, 6'd0, 16'd8, 16'd2);
    send(6'd62, 6'd0, 16'd2, 1'b1);
    drain("R7 pair completes");

    // R8/R9: consumer held off, four firing pairs of two results each.
    @(posedge clk);
    #1 res_ready = 1'b0;
    for (int i = 0; i < 4; i++) expect_fire(6'(40 + i * 2), 6'd0, 16'(i * 11 + 1), 16'(i * 3 + 2));
    fork
      begin
        for (int i = 0; i < 4; i++) begin
          send(6'(40 + i * 2), 6'd0, 16'(i * 11 + 1), 1'b0);
          send(6'(40 + i * 2), 6'd0, 16'(i * 3 + 2), 1'b1);
        end
      end
      begin
        logic [15:0] hd;
        logic [5:0]  hi;
        repeat (40) @(negedge clk);
        #2;
        check(tok_ready == 1'b0, "R9 input stalls when results cannot fit", tok_ready, 0);
        check(res_valid == 1'b1, "R8 head result waiting", res_valid, 1);
        hd = res_data; hi = res_ip;
        repeat (3) @(negedge clk);
        #2;
        check(res_data == hd && res_ip == hi, "R8 head holds steady", {res_ip, res_data}, {hi, hd});
        @(posedge clk);
        #1 res_ready = 1'b1;
      end
    join
    drain("R9 no token lost after stall");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule